// File: doc/BRIEF.md
# Windowed Integer Register File

This block is an integer register file for a processor that uses overlapping register windows. At any moment a program sees 32 register numbers. Eight of them are globals, which are the same in every window. The other 24 are windowed, and a current-window pointer maps them onto a larger physical array. Within a window, eight registers are private locals. The other sixteen are shared with the two neighbouring windows. A caller's outgoing registers are physically the callee's incoming registers, so parameters and return values pass between them without any copying.

The register file has two combinational read ports and one write port. Two commands move the window: save for a call and restore for a return. An external controller supplies a mask of windows that have been spilled to memory. The block does not move into a window that the mask marks. Instead it raises an overflow or underflow flag for one cycle, and the controller acts on that flag. The number of windows is a parameter, from 1 up to 32.

Top module: `winreg_file`

## Requirements
- R1: After reset, the window pointer is 0, both flags are low, and every register reads zero.
- R2: Register number 0 always reads zero, and writes to it have no effect.
- R3: Register numbers 1 to 7 are globals and address the same storage in every window.
- R4: Register numbers 16 to 23 are locals, and each window has its own copy.
- R5: Register numbers 8 to 15 (outs) of window w are the same storage as register numbers 24 to 31 (ins) of window (w-1) mod NWIN.
- R6: Save loads the pointer with (w-1) mod NWIN at the next clock edge, and restore loads it with (w+1) mod NWIN, wrapping at both ends. With neither command, the pointer holds.
- R7: A save whose target window has its mask bit set leaves the pointer unchanged and raises the overflow flag for exactly one cycle.
- R8: A restore whose target window has its mask bit set leaves the pointer unchanged and raises the underflow flag for exactly one cycle.
- R9: A read of the physical register being written in the same cycle returns the new write data.
- R10: When save and restore are both requested, only the save is acted on.
- R11: Reads and writes in a cycle that carries a save or restore use the window in effect before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Read port A register number |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | 5 | Read port B register number |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register number |
| wr_data | input | DW | Write data |
| save_req | input | 1 | Move to the next window down (call) |
| restore_req | input | 1 | Move to the next window up (return) |
| inval_mask | input | NWIN | One bit per window; set means the window is spilled and must not be entered |
| cwp | output | max(1,clog2(NWIN)) | Current window pointer |
| ovf | output | 1 | One-cycle overflow flag |
| unf | output | 1 | One-cycle underflow flag |

## Verification
The assertions assume that the save and restore inputs, and the mask, are stable around the clock edge. They also assume the mask has NWIN valid bits. The bench changes these inputs only on falling edges, so both assumptions hold. The bench does not assume that the controller clears a request after a flag. It removes the request itself on the next falling edge and then checks that the flag has dropped, so each flag is tested as a single-cycle pulse. The stimulus includes saves, restores and writes issued together with reads in the same cycle, which covers the bypass and the rule that a command-cycle access uses the old window.

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [4:0]                           rd_a_idx,
  output logic [DW-1:0]                        rd_a_data,
  input  logic [4:0]                           rd_b_idx,
  output logic [DW-1:0]                        rd_b_data,
  input  logic                                 wr_en,
  input  logic [4:0]                           wr_idx,
  input  logic [DW-1:0]                        wr_data,
  input  logic                                 save_req,
  input  logic                                 restore_req,
  input  logic [NWIN-1:0]                      inval_mask,
  output logic [(NWIN>1?$clog2(NWIN):1)-1:0]   cwp,
  output logic                                 ovf,
  output logic                                 unf
);
  localparam int NPHYS = 8 + 16*NWIN;
  localparam int PW    = $clog2(NPHYS);
  localparam int CW    = NWIN > 1 ? $clog2(NWIN) : 1;

  logic [DW-1:0] rf [NPHYS];
  logic [CW-1:0] w_dn, w_up;
  logic [PW-1:0] pa, pb, pw;
  logic          wr_live;

  function automatic logic [PW-1:0] map_phys(input logic [4:0] r,
                                             input logic [CW-1:0] w,
                                             input logic [CW-1:0] wo);
    int b;
    case (r[4:3])
      2'd0:    b = int'(r);
      2'd1:    b = 16 + 16*int'(wo) + int'(r[2:0]);
      2'd2:    b = 8  + 16*int'(w)  + int'(r[2:0]);
      default: b = 16 + 16*int'(w)  + int'(r[2:0]);
    endcase
    return PW'(b);
  endfunction

  assign w_dn = (cwp == '0) ? CW'(NWIN-1) : cwp - 1'b1;
  assign w_up = (cwp == CW'(NWIN-1)) ? '0 : cwp + 1'b1;

  assign pa = map_phys(rd_a_idx, cwp, w_dn);
  assign pb = map_phys(rd_b_idx, cwp, w_dn);
  assign pw = map_phys(wr_idx,   cwp, w_dn);

  assign wr_live = wr_en && (wr_idx != 5'd0);

  assign rd_a_data = (rd_a_idx == 5'd0) ? '0 :
                     (wr_live && pw == pa) ? wr_data : rf[pa];
  assign rd_b_data = (rd_b_idx == 5'd0) ? '0 :
                     (wr_live && pw == pb) ? wr_data : rf[pb];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) rf[i] <= '0;
    end else if (wr_live) begin
      rf[pw] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      if (save_req) begin
        if (inval_mask[w_dn]) ovf <= 1'b1;
        else                  cwp <= w_dn;
      end else if (restore_req) begin
        if (inval_mask[w_up]) unf <= 1'b1;
        else                  cwp <= w_up;
      end
    end
  end
endmodule

module winreg_file_chk #(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               save_req,
  input logic                               restore_req,
  input logic [4:0]                         rd_a_idx,
  input logic [DW-1:0]                      rd_a_data,
  input logic [4:0]                         rd_b_idx,
  input logic [DW-1:0]                      rd_b_data,
  input logic [(NWIN>1?$clog2(NWIN):1)-1:0] cwp,
  input logic                               ovf,
  input logic                               unf
);
  localparam int CW = NWIN > 1 ? $clog2(NWIN) : 1;

  // R2
  zero_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == 5'd0 |-> rd_a_data == '0);
  // R2
  zero_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_idx == 5'd0 |-> rd_b_data == '0);
  // R6
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cwp) < NWIN);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !save_req && !restore_req |=> $stable(cwp));
  // R6
  save_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_req |=> ovf || cwp == (($past(cwp) == '0) ? CW'(NWIN-1) : $past(cwp) - 1'b1));
  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> cwp == $past(cwp));
  // R8
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> cwp == $past(cwp));
  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));
  // R10
  save_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_req |=> !unf);
endmodule

bind winreg_file winreg_file_chk #(.NWIN(NWIN), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx),
  .rd_b_data(rd_b_data), .cwp(cwp), .ovf(ovf), .unf(unf)
);

// File: tb/winreg_file_tb.sv
`timescale 1ns/1ps
module winreg_file_tb;
  localparam int NWIN = 8;
  localparam int DW   = 32;
  localparam int CW   = 3;

  logic          clk = 0, rst_n = 0;
  logic [4:0]    rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = 0;
  logic          wr_en = 0, save_req = 0, restore_req = 0;
  logic [NWIN-1:0] inval_mask = 0;
  logic [CW-1:0] cwp;
  logic          ovf, unf;

  int runs = 0, fails = 0;
  bit done = 0;

  typedef struct { int kind; logic [DW-1:0] exp; string req; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  winreg_file #(.NWIN(NWIN), .DW(DW)) u_dut (.*);

  // kind: 0 read A, 1 read B, 2 cwp, 3 ovf, 4 unf
  task automatic expect_v(input int kind, input logic [DW-1:0] e, input string r);
    item_t it;
    it.kind = kind; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  // Drive one cycle of stimulus at the falling edge; checks pushed here see its results.
  task automatic cyc(input logic [4:0] ra, input logic [4:0] rb,
                     input logic we, input logic [4:0] wi, input logic [DW-1:0] wd,
                     input logic sv, input logic rs);
    @(negedge clk);
    rd_a_idx = ra; rd_b_idx = rb; wr_en = we; wr_idx = wi; wr_data = wd;
    save_req = sv; restore_req = rs;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        logic [DW-1:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = rd_a_data;
          1: act = rd_b_data;
          2: act = DW'(cwp);
          3: act = DW'(ovf);
          default: act = DW'(unf);
        endcase
        runs++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #(8*20000);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cyc(5, 24, 0, 0, 0, 0, 0);
    expect_v(2, 0, "R1"); expect_v(3, 0, "R1"); expect_v(4, 0, "R1");
    expect_v(0, 0, "R1"); expect_v(1, 0, "R1");
    // R2 write to register 0 ignored; global write
    cyc(0, 1, 1, 0, 32'hdead, 0, 0);
    cyc(0, 1, 1, 1, 32'h11, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0);
    expect_v(0, 0, "R2"); expect_v(1, 32'h11, "R3");
    // R9 bypass
    cyc(2, 3, 1, 2, 32'h22, 0, 0);
    expect_v(0, 32'h22, "R9"); expect_v(1, 0, "R9");
    // Window 0: out r8, local r16, in r24
    cyc(0, 0, 1, 8, 32'hA0, 0, 0);
    cyc(0, 0, 1, 16, 32'hB0, 0, 0);
    cyc(0, 0, 1, 24, 32'hC0, 0, 0);
    // Save: 0 -> 7
    cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(24, 16, 0, 0, 0, 0, 0);
    expect_v(2, 7, "R6"); expect_v(0, 32'hA0, "R5"); expect_v(1, 0, "R4");
    cyc(1, 2, 0, 0, 0, 0, 0);
    expect_v(0, 32'h11, "R3"); expect_v(1, 32'h22, "R3");
    // In window 7 write local and out
    cyc(0, 0, 1, 16, 32'hB7, 0, 0);
    cyc(0, 0, 1, 8, 32'hD7, 0, 0);
    // Restore: 7 -> 0
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(16, 8, 0, 0, 0, 0, 0);
    expect_v(2, 0, "R6"); expect_v(0, 32'hB0, "R4"); expect_v(1, 32'hA0, "R5");
    cyc(24, 0, 0, 0, 0, 0, 0);
    expect_v(0, 32'hC0, "R5");
    // Restore 0 -> 1; outs of 1 are ins of 0
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(8, 16, 0, 0, 0, 0, 0);
    expect_v(2, 1, "R6"); expect_v(0, 32'hC0, "R5"); expect_v(1, 0, "R4");
    cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    expect_v(2, 0, "R6");
    // R7 overflow: window 7 invalid
    inval_mask = 8'h80;
    cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(16, 0, 0, 0, 0, 0, 0);
    expect_v(3, 1, "R7"); expect_v(4, 0, "R7"); expect_v(2, 0, "R7");
    expect_v(0, 32'hB0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 0);
    expect_v(3, 0, "R7"); expect_v(2, 0, "R7");
    // R8 underflow: window 1 invalid
    inval_mask = 8'h02;
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    expect_v(4, 1, "R8"); expect_v(3, 0, "R8"); expect_v(2, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0);
    expect_v(4, 0, "R8");
    // R10 both requested: save wins, 0 -> 7
    inval_mask = 0;
    cyc(0, 0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    expect_v(2, 7, "R10"); expect_v(4, 0, "R10");
    // R11 write and read in the save cycle use window 7
    cyc(16, 0, 1, 16, 32'h55, 1, 0);
    expect_v(0, 32'h55, "R11");
    cyc(16, 0, 0, 0, 0, 0, 0);
    expect_v(2, 6, "R11"); expect_v(0, 0, "R11");
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(16, 0, 0, 0, 0, 0, 0);
    expect_v(2, 7, "R11"); expect_v(0, 32'h55, "R11");
    // outs of 7 written earlier appear as ins of 6
    cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(24, 0, 0, 0, 0, 0, 0);
    expect_v(2, 6, "R5"); expect_v(0, 32'hD7, "R5");
    cyc(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    #4;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule